// File: doc/BRIEF.md
# Serial Link Word Slot Arbiter

This block chooses the 48-bit word that fills each word slot of a serial link and hands it out one 8-bit character per clock, with a control flag per character, to a downstream 8b10b encoder. A word slot lasts six clocks. Five word sources compete for each slot: test pattern, user control word, serial time, frame and hit data. Each has a valid strobe, a payload and a grant.

On its own the block produces link synchronisation words. It sends a fixed-length burst of them after reset or after a restart pulse. It also sends them for as long as a hold input stays high. When no source is pending it fills the slot with an idle word, which is the same as the sync word.

The source interfaces follow valid/grant (ready) rules. A source raises `*_valid` and keeps its payload stable. The grant is high for exactly one cycle, the last cycle of a slot. The payload is taken at the clock edge that ends that cycle, and the source may then pop or change it. A source that is not granted keeps its request pending. Nothing is lost, and a request is only looked at in the last cycle of a slot.

Top module: `link_slot_arbiter`

## Requirements
- R1: Each word slot lasts CHARS (6) cycles. Characters leave most significant first, bits 47..40 first. `tx_first` is high exactly while the first character of a slot is on `tx_char`.
- R2: The sync word and the idle word each consist of five 0xBC characters followed by one 0xFB character, all with `tx_k` = 1. During reset, `tx_char` = 0xBC, `tx_k` = 1, `tx_first` = 0 and all grants are 0.
- R3: After reset is released, the first SYNC_BURST_LEN slots carry sync words and no grant is given in them, even if every source is valid.
- R4: A one-cycle `restart_burst` pulse makes the next SYNC_BURST_LEN slots that start after that cycle carry sync words. A slot that starts at the same edge is still arbitrated normally.
- R5: While `sync_hold` is high in the last cycle of a slot, the next slot carries a sync word and no grant is given.
- R6: The sources rank from highest to lowest as test pattern, control word, serial time, frame, data. Only the highest-ranked valid source is granted.
- R7: A grant is a one-cycle pulse in the last cycle of a slot, and only for a valid source. The granted payload fills the next slot.
- R8: In test pattern and control word slots, mask bit 5 gives the flag of the first character and bit 0 that of the last. Serial time, frame and data slots have every flag clear.
- R9: When no source is valid and no sync is due, the slot carries the idle word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync domain clock |
| rst_n | input | 1 | Active-low reset, starts a sync burst |
| restart_burst | input | 1 | One-cycle command that restarts the sync burst |
| sync_hold | input | 1 | Configuration bit: send sync words while high |
| tp_valid | input | 1 | Test pattern word pending |
| tp_word | input | 48 | Test pattern payload |
| tp_kmask | input | 6 | Per-character control flags for the test pattern |
| kw_valid | input | 1 | User control word pending |
| kw_word | input | 48 | User control word payload |
| kw_kmask | input | 6 | Per-character control flags for the control word |
| st_valid | input | 1 | Serial time word pending |
| st_word | input | 48 | Serial time payload |
| fr_valid | input | 1 | Frame word pending |
| fr_word | input | 48 | Frame payload |
| dt_valid | input | 1 | Hit data word pending |
| dt_word | input | 48 | Hit data payload |
| tp_grant | output | 1 | Test pattern taken at this edge |
| kw_grant | output | 1 | Control word taken at this edge |
| st_grant | output | 1 | Serial time word taken at this edge |
| fr_grant | output | 1 | Frame word taken at this edge |
| dt_grant | output | 1 | Data word taken at this edge |
| tx_char | output | 8 | Character to the encoder |
| tx_k | output | 1 | Control-character flag for `tx_char` |
| tx_first | output | 1 | First character of a slot |

## Verification
The hardest cases are the ones where a restart command hits the last cycle of a slot rather than the middle of one. In the first case the slot loaded at that edge must still go to the winning source; in the second the very next slot must already be sync. The bench builds the design with a three-word burst and keeps its own slot phase. It can therefore place the restart pulse on either kind of cycle while every source is pending, and check that grants resume exactly three slots later. Every one of the 32 valid combinations is also swept once the burst has ended.

// File: rtl/link_slot_pkg.sv
package link_slot_pkg;
  localparam int          CHAR_W  = 8;
  localparam logic [7:0]  K_COMMA = 8'hBC;  // K28.5
  localparam logic [7:0]  K_TAIL  = 8'hFB;  // K27.7
  localparam int          NSRC    = 5;      // tp, kw, st, fr, dt
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int CHARS = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_last,
  output logic slot_first
);
  localparam int CW = (CHARS > 1) ? $clog2(CHARS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHARS - 1);

  logic [CW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pos <= LAST;
    else if (pos == LAST)  pos <= '0;
    else                   pos <= pos + 1'b1;
  end

  assign slot_last  = (pos == LAST);
  assign slot_first = (pos == '0) && rst_n;

  // R1: position wraps after CHARS cycles
  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST) |=> (pos == '0));
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != LAST) |=> (pos == $past(pos) + 1'b1));
endmodule

// File: rtl/sync_burst.sv
module sync_burst #(
  parameter int LEN = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic active
);
  localparam int BW = $clog2(LEN + 1);
  localparam logic [BW-1:0] FULL = BW'(LEN);

  logic [BW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 left <= FULL;
    else if (restart)           left <= FULL;
    else if (step && active)    left <= left - 1'b1;
  end

  assign active = (left != '0);

  // R4: a restart reloads the full burst length
  p_restart_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (left == FULL));
endmodule

// File: rtl/fixed_prio.sv
module fixed_prio #(
  parameter int N = 5
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rank
    assign blocked[i+1] = blocked[i] | req[i];
    assign gnt[i]       = en & req[i] & ~blocked[i];
  end

  // R6: never more than one winner
  always_comb begin
    p_single_winner_r6: assert ($onehot0(gnt));
  end
endmodule

// File: rtl/char_shifter.sv
module char_shifter
  import link_slot_pkg::*;
#(
  parameter int CHARS = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CHARS*CHAR_W-1:0]   word_in,
  input  logic [CHARS-1:0]          kmask_in,
  output logic [CHAR_W-1:0]         char_out,
  output logic                      k_out
);
  localparam int W = CHARS * CHAR_W;

  function automatic logic [W-1:0] sync_word();
    logic [W-1:0] w;
    for (int i = 0; i < CHARS; i++)
      w[i*CHAR_W +: CHAR_W] = (i == 0) ? K_TAIL : K_COMMA;
    return w;
  endfunction

  logic [W-1:0]     sh;
  logic [CHARS-1:0] km;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= sync_word();
      km <= '1;
    end else if (load) begin
      sh <= word_in;
      km <= kmask_in;
    end else begin
      sh <= sh << CHAR_W;
      km <= km << 1;
    end
  end

  assign char_out = sh[W-1 -: CHAR_W];
  assign k_out    = km[CHARS-1];
endmodule

// File: rtl/link_slot_arbiter.sv
module link_slot_arbiter
  import link_slot_pkg::*;
#(
  parameter int CHARS          = 6,
  parameter int SYNC_BURST_LEN = 65536
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart_burst,
  input  logic                    sync_hold,
  input  logic                    tp_valid,
  input  logic [CHARS*8-1:0]      tp_word,
  input  logic [CHARS-1:0]        tp_kmask,
  input  logic                    kw_valid,
  input  logic [CHARS*8-1:0]      kw_word,
  input  logic [CHARS-1:0]        kw_kmask,
  input  logic                    st_valid,
  input  logic [CHARS*8-1:0]      st_word,
  input  logic                    fr_valid,
  input  logic [CHARS*8-1:0]      fr_word,
  input  logic                    dt_valid,
  input  logic [CHARS*8-1:0]      dt_word,
  output logic                    tp_grant,
  output logic                    kw_grant,
  output logic                    st_grant,
  output logic                    fr_grant,
  output logic                    dt_grant,
  output logic [7:0]              tx_char,
  output logic                    tx_k,
  output logic                    tx_first
);
  localparam int W = CHARS * CHAR_W;

  logic            slot_last;
  logic            burst_on;
  logic            sync_now;
  logic [NSRC-1:0] req, gnt;
  logic [W-1:0]     src_word [NSRC];
  logic [CHARS-1:0] src_km   [NSRC];
  logic [W-1:0]     nxt_word;
  logic [CHARS-1:0] nxt_km;

  slot_timer #(.CHARS(CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_last(slot_last), .slot_first(tx_first)
  );

  sync_burst #(.LEN(SYNC_BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .restart(restart_burst),
    .step(slot_last), .active(burst_on)
  );

  assign sync_now = burst_on | sync_hold;
  assign req      = {dt_valid, fr_valid, st_valid, kw_valid, tp_valid};

  fixed_prio #(.N(NSRC)) u_prio (
    .en(slot_last & ~sync_now), .req(req), .gnt(gnt)
  );

  assign src_word[0] = tp_word;  assign src_km[0] = tp_kmask;
  assign src_word[1] = kw_word;  assign src_km[1] = kw_kmask;
  assign src_word[2] = st_word;  assign src_km[2] = '0;
  assign src_word[3] = fr_word;  assign src_km[3] = '0;
  assign src_word[4] = dt_word;  assign src_km[4] = '0;

  always_comb begin
    for (int i = 0; i < CHARS; i++)
      nxt_word[i*CHAR_W +: CHAR_W] = (i == 0) ? K_TAIL : K_COMMA;
    nxt_km = '1;
    for (int s = 0; s < NSRC; s++) begin
      if (gnt[s]) begin
        nxt_word = src_word[s];
        nxt_km   = src_km[s];
      end
    end
  end

  char_shifter #(.CHARS(CHARS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(slot_last),
    .word_in(nxt_word), .kmask_in(nxt_km),
    .char_out(tx_char), .k_out(tx_k)
  );

  assign {dt_grant, fr_grant, st_grant, kw_grant, tp_grant} = gnt;

  // R7: a grant is followed by the first character of a new slot
  p_grant_then_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> tx_first);
  // R7: grants last one cycle
  p_grant_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> !(|gnt));
  // R5: hold at a slot end yields a sync character next
  p_hold_gives_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last && sync_hold) |=> (tx_char == K_COMMA && tx_k && tx_first));
endmodule

// File: tb/link_slot_arbiter_bench.sv
module link_slot_arbiter_bench;
  localparam int CHARS = 6;
  localparam int LEN   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_burst = 1'b0, sync_hold = 1'b0;
  logic tp_valid = 0, kw_valid = 0, st_valid = 0, fr_valid = 0, dt_valid = 0;
  logic [47:0] tp_word, kw_word, st_word, fr_word, dt_word;
  logic [5:0]  tp_kmask, kw_kmask;
  logic tp_grant, kw_grant, st_grant, fr_grant, dt_grant;
  logic [7:0] tx_char;
  logic tx_k, tx_first;

  int n_cmp = 0, n_bad = 0, model_left = LEN;
  bit done = 0;

  always #5 clk = ~clk;

  link_slot_arbiter #(.CHARS(CHARS), .SYNC_BURST_LEN(LEN)) u_link_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .restart_burst(restart_burst), .sync_hold(sync_hold),
    .tp_valid(tp_valid), .tp_word(tp_word), .tp_kmask(tp_kmask),
    .kw_valid(kw_valid), .kw_word(kw_word), .kw_kmask(kw_kmask),
    .st_valid(st_valid), .st_word(st_word), .fr_valid(fr_valid), .fr_word(fr_word),
    .dt_valid(dt_valid), .dt_word(dt_word),
    .tp_grant(tp_grant), .kw_grant(kw_grant), .st_grant(st_grant),
    .fr_grant(fr_grant), .dt_grant(dt_grant),
    .tx_char(tx_char), .tx_k(tx_k), .tx_first(tx_first));

  function automatic logic [7:0] pchar(int s, int c);
    return 8'(s * 37 + c * 11 + 5);
  endfunction

  function automatic logic [5:0] pmask(int s);
    return (s == 0) ? 6'b100101 : (s == 1) ? 6'b011010 : 6'b000000;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] gvec();
    return {dt_grant, fr_grant, st_grant, kw_grant, tp_grant};
  endfunction

  // Called at the falling edge inside a slot's last cycle; returns at the next one.
  task automatic slot(input logic [4:0] v, input logic hold, input int rc_mode);
    bit sync;
    int win;
    logic [4:0] eg;
    {dt_valid, fr_valid, st_valid, kw_valid, tp_valid} = v;
    sync_hold = hold;
    restart_burst = (rc_mode == 1);
    #1;
    sync = (model_left != 0) || hold;
    win = -1;
    for (int s = 4; s >= 0; s--) if (v[s]) win = s;
    eg = (sync || win < 0) ? 5'd0 : 5'(1 << win);
    chk(sync ? "R3/R5 grants blocked" : "R6/R7 grant vector", 64'(gvec()), 64'(eg));
    if (model_left != 0) model_left--;
    if (rc_mode != 0) model_left = LEN;
    for (int c = 0; c < CHARS; c++) begin
      @(negedge clk);
      if (c == 0) restart_burst = 1'b0;
      if (c == 2 && rc_mode == 2) restart_burst = 1'b1;
      if (c == 3) restart_burst = 1'b0;
      chk("R1 tx_first", 64'(tx_first), 64'(c == 0));
      if (sync || win < 0) begin
        chk("R2/R9 sync-idle char", 64'(tx_char), 64'((c == CHARS-1) ? 8'hFB : 8'hBC));
        chk("R2/R9 sync-idle flag", 64'(tx_k), 64'd1);
      end else begin
        chk("R1 payload char", 64'(tx_char), 64'(pchar(win, c)));
        chk("R8 char flag", 64'(tx_k), 64'(pmask(win)[5-c]));
      end
      if (c < CHARS-1) chk("R7 no grant mid-slot", 64'(gvec()), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 6; c++) begin
      tp_word[47-8*c -: 8] = pchar(0, c);
      kw_word[47-8*c -: 8] = pchar(1, c);
      st_word[47-8*c -: 8] = pchar(2, c);
      fr_word[47-8*c -: 8] = pchar(3, c);
      dt_word[47-8*c -: 8] = pchar(4, c);
    end
    tp_kmask = pmask(0);
    kw_kmask = pmask(1);
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset char", 64'(tx_char), 64'hBC);
    chk("R2 reset flag", 64'(tx_k), 64'd1);
    chk("R2 reset first", 64'(tx_first), 64'd0);
    chk("R2 reset grants", 64'(gvec()), 64'd0);
    rst_n = 1'b1;
    // R3: burst after reset blocks all sources, then test pattern wins
    for (int i = 0; i < LEN + 1; i++) slot(5'b11111, 1'b0, 0);
    // R6 R8 R9: sweep all valid combinations
    for (int m = 0; m < 32; m++) slot(5'(m), 1'b0, 0);
    // R5: hold forces sync
    slot(5'b11110, 1'b1, 0);
    slot(5'b11111, 1'b1, 0);
    slot(5'b10000, 1'b0, 0);
    // R4: restart mid-slot, then restart on the slot's last cycle
    slot(5'b11100, 1'b0, 2);
    for (int i = 0; i < LEN + 1; i++) slot(5'b11100, 1'b0, 0);
    slot(5'b01000, 1'b0, 1);
    for (int i = 0; i < LEN + 1; i++) slot(5'b01000, 1'b0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule